// File: doc/BRIEF.md
# Multi-Stage LLR Update Unit

This unit is the soft-message arithmetic of a successive-cancellation polar decoder for the lower levels of the decoding tree. Every LLR belonging to tree stages at or below the parallelism threshold (node size equal to `PE`) sits in one packed word of `2*PE` signed 6-bit entries. In a single cycle, the unit takes that word and runs a chain of one to three tree updates on it. Each update is a left-child (min-sum) update, a right-child update that uses partial sums, or a right-child update whose left partial sums are all zero. For each opcode, the unit decides which results of the chain are written back into the packed word.

Above the threshold, the same unit runs single updates on a full-width word. In that case the two halves of the word are the two halves of the node. The unit has no storage apart from its output register. The word comes from the soft-message memory and goes back to it, and that memory is outside the block.

Top module: `llrStageUnit`

## Requirements
- R1: A left update of entries x and y gives sign(x)·sign(y)·min(|x|,|y|). The sign is negative exactly when the two sign bits differ. The result saturates to [-32, 31], so two entries of -32 give +31.
- R2: A right update gives y+x when the partial-sum bit is 0 and y−x when it is 1. The result saturates to [-32, 31]. Partial-sum bit i (port `partialSum[i]`) goes with output entry i.
- R3: A zero-left right update ignores the partial sums and gives the saturated sum y+x.
- R4: Entry i of a word occupies bits [6i+5:6i]. Stage s (for 2 ≤ s ≤ log2 PE) occupies 2^s entries starting at entry 2·PE−2^(s+1). An update at stage s reads x_i = entry (off+i) and y_i = entry (off+i+2^(s-1)) for i < 2^(s-1), and writes stage s−1. Entries that no stored step writes, including the last 4 spare entries, keep their input value.
- R5: Opcodes: 0 F, 1 G, 2 G0, 3 F2, 4 F3, 5 G0x2, 6 G0x3, 7 GF (G then F), 8 FG0 (F then G0). A chain starts at `startStage` and each step lowers the stage by one. F2 and F3 store the result of every step.
- R6: G0x2 and G0x3 store only their last step. The regions of the earlier steps keep their input value.
- R7: GF stores both the right-update result and the left update that follows it.
- R8: FG0 stores only its final zero-left result. The region of the left-update step keeps its input value.
- R9: When `startStage` > log2 PE, opcodes 0 to 2 work on the full word. Entry i < PE takes the update of x = entry i and y = entry i+PE, with partial-sum bit i. Entries PE and above are unchanged.
- R10: Some requests are rejected: opcodes 9 to 15, a merged opcode with `startStage` > log2 PE, and a chain that would write below stage 2 (`startStage` < steps+2). A rejected request raises `outReject` and returns the input word unchanged.
- R11: Results appear one clock after a cycle with `inValid` high, and `outValid` is high for exactly that one cycle. Reset clears `outValid`, `outReject` and `outWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opcode | input | 4 | Update opcode (R5) |
| startStage | input | STW | Tree stage of the node being updated |
| inWord | input | 2·PE·6 | Packed LLR word |
| partialSum | input | PE | Left-child partial-sum bits |
| outValid | output | 1 | Result strobe |
| outReject | output | 1 | Request was rejected |
| outWord | output | 2·PE·6 | Updated word |

## Verification
The hardest case to reach is a three-step chain that ends exactly at stage 2. At the bench parameter (PE = 32), only a start at the threshold stage gets there without being rejected. The stimulus runs F3 and G0x3 from stage 5, with random words padded by saturation extremes. It also runs each merged pair from more than one start stage, so that the regions that must be kept and the regions that must be overwritten both change position. The boundary of the reject rule is approached from both sides, once with the lowest valid start and once with one stage less.

// File: rtl/llrStagePkg.sv
package llrStagePkg;

  localparam int LLR_W = 6;

  typedef enum logic [3:0] {
    OP_F   = 4'd0,
    OP_G   = 4'd1,
    OP_G0  = 4'd2,
    OP_F2  = 4'd3,
    OP_F3  = 4'd4,
    OP_G02 = 4'd5,
    OP_G03 = 4'd6,
    OP_GF  = 4'd7,
    OP_FG0 = 4'd8
  } opT;

  typedef enum logic [1:0] {
    K_F  = 2'd0,
    K_G  = 2'd1,
    K_G0 = 2'd2
  } kindT;

  // strobes from control to datapath
  typedef struct packed {
    logic       hi;      // full-width single update
    logic       reject;  // request refused
    logic [1:0] nSteps;  // chained steps, 1..3
    kindT       k0;
    kindT       k1;
    kindT       k2;
    logic [2:0] keep;    // bit j: store result of step j
  } ctrlT;

  function automatic logic signed [LLR_W-1:0] satLlr(input logic signed [LLR_W+1:0] x);
    logic signed [LLR_W+1:0] hiL;
    logic signed [LLR_W+1:0] loL;
    hiL = (LLR_W+2)'((1 << (LLR_W-1)) - 1);
    loL = -hiL - (LLR_W+2)'(1);
    if (x > hiL) return hiL[LLR_W-1:0];
    if (x < loL) return loL[LLR_W-1:0];
    return x[LLR_W-1:0];
  endfunction

  function automatic logic signed [LLR_W-1:0] applyOp(input kindT k,
      input logic signed [LLR_W-1:0] x, input logic signed [LLR_W-1:0] y, input logic bt);
    logic signed [LLR_W+1:0] xe;
    logic signed [LLR_W+1:0] ye;
    logic signed [LLR_W+1:0] mx;
    logic signed [LLR_W+1:0] my;
    logic signed [LLR_W+1:0] m;
    xe = (LLR_W+2)'(x);
    ye = (LLR_W+2)'(y);
    case (k)
      K_F: begin
        mx = xe[LLR_W+1] ? -xe : xe;
        my = ye[LLR_W+1] ? -ye : ye;
        m  = (mx < my) ? mx : my;
        return satLlr((x[LLR_W-1] ^ y[LLR_W-1]) ? -m : m);
      end
      K_G:     return satLlr(bt ? (ye - xe) : (ye + xe));
      default: return satLlr(ye + xe);
    endcase
  endfunction

endpackage

// File: rtl/llrStageCtrl.sv
module llrStageCtrl
  import llrStagePkg::*;
#(
  parameter int PE  = 64,
  parameter int STW = 5
) (
  input  logic [3:0]     opcode,
  input  logic [STW-1:0] startStage,
  output ctrlT           ctrl
);

  localparam int THRESH = $clog2(PE);

  logic badOp;
  logic hiStage;

  always_comb begin
    ctrl   = '0;
    badOp  = 1'b0;
    ctrl.k0 = K_F;
    ctrl.k1 = K_F;
    ctrl.k2 = K_F;
    case (opcode)
      OP_F:   begin ctrl.nSteps = 2'd1; ctrl.k0 = K_F;  ctrl.keep = 3'b001; end
      OP_G:   begin ctrl.nSteps = 2'd1; ctrl.k0 = K_G;  ctrl.keep = 3'b001; end
      OP_G0:  begin ctrl.nSteps = 2'd1; ctrl.k0 = K_G0; ctrl.keep = 3'b001; end
      OP_F2:  begin ctrl.nSteps = 2'd2; ctrl.keep = 3'b011; end
      OP_F3:  begin ctrl.nSteps = 2'd3; ctrl.keep = 3'b111; end
      OP_G02: begin ctrl.nSteps = 2'd2; ctrl.k0 = K_G0; ctrl.k1 = K_G0; ctrl.keep = 3'b010; end
      OP_G03: begin
        ctrl.nSteps = 2'd3; ctrl.k0 = K_G0; ctrl.k1 = K_G0; ctrl.k2 = K_G0; ctrl.keep = 3'b100;
      end
      OP_GF:  begin ctrl.nSteps = 2'd2; ctrl.k0 = K_G; ctrl.k1 = K_F;  ctrl.keep = 3'b011; end
      OP_FG0: begin ctrl.nSteps = 2'd2; ctrl.k0 = K_F; ctrl.k1 = K_G0; ctrl.keep = 3'b010; end
      default: begin ctrl.nSteps = 2'd1; badOp = 1'b1; end
    endcase
    hiStage     = int'(startStage) > THRESH;
    ctrl.hi     = hiStage;
    ctrl.reject = badOp
                || (hiStage && ctrl.nSteps != 2'd1)
                || (!hiStage && int'(startStage) < int'(ctrl.nSteps) + 2);
  end

  // R10: a merged opcode never reaches full-width mode
  always_comb begin
    if (!ctrl.reject && ctrl.hi)
      a_r10_hi_single: assert (opcode <= 4'd2);
  end

endmodule

// File: rtl/llrStageDatapath.sv
module llrStageDatapath
  import llrStagePkg::*;
#(
  parameter int PE  = 64,
  parameter int STW = 5
) (
  input  ctrlT                     ctrl,
  input  logic [STW-1:0]           startStage,
  input  logic [2*PE*LLR_W-1:0]    word,
  input  logic [PE-1:0]            beta,
  output logic [2*PE*LLR_W-1:0]    result
);

  localparam int NE    = 2 * PE;
  localparam int SPARE = 4;

  logic signed [LLR_W-1:0] src  [NE];
  logic signed [LLR_W-1:0] work [NE];
  logic signed [LLR_W-1:0] res  [NE];

  always_comb begin
    for (int i = 0; i < NE; i++) src[i] = word[i*LLR_W +: LLR_W];
  end

  always_comb begin
    int   s;
    int   half;
    int   offS;
    int   offD;
    kindT kk;
    logic signed [LLR_W-1:0] v;
    work = src;
    res  = src;
    v    = '0;
    kk   = K_F;
    if (!ctrl.reject) begin
      if (ctrl.hi) begin
        for (int i = 0; i < PE; i++)
          res[i] = applyOp(ctrl.k0, src[i], src[i+PE], beta[i]);
      end else begin
        for (int j = 0; j < 3; j++) begin
          if (j < int'(ctrl.nSteps)) begin
            s    = int'(startStage) - j;
            half = 1 << (s - 1);
            offS = NE - (2 << s);
            offD = NE - (1 << s);
            case (j)
              0:       kk = ctrl.k0;
              1:       kk = ctrl.k1;
              default: kk = ctrl.k2;
            endcase
            for (int i = 0; i < PE/2; i++) begin
              if (i < half) begin
                v = applyOp(kk, work[offS+i], work[offS+i+half], beta[i]);
                work[offD+i] = v;
                if (ctrl.keep[j]) res[offD+i] = v;
              end
            end
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NE; i++) result[i*LLR_W +: LLR_W] = res[i];
  end

  // R4: spare tail of the packed word is never written in packed mode
  always_comb begin
    if (!ctrl.hi)
      for (int i = NE - SPARE; i < NE; i++)
        a_r4_spare_kept: assert (result[i*LLR_W +: LLR_W] == word[i*LLR_W +: LLR_W]);
  end

  // R9: full-width updates leave the upper half alone
  always_comb begin
    if (ctrl.hi)
      for (int i = PE; i < NE; i++)
        a_r9_upper_kept: assert (result[i*LLR_W +: LLR_W] == word[i*LLR_W +: LLR_W]);
  end

endmodule

// File: rtl/llrStageUnit.sv
module llrStageUnit
  import llrStagePkg::*;
#(
  parameter int PE  = 64,
  parameter int STW = 5
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      inValid,
  input  logic [3:0]                opcode,
  input  logic [STW-1:0]            startStage,
  input  logic [2*PE*LLR_W-1:0]     inWord,
  input  logic [PE-1:0]             partialSum,
  output logic                      outValid,
  output logic                      outReject,
  output logic [2*PE*LLR_W-1:0]     outWord
);

  ctrlT                   ctrl;
  logic [2*PE*LLR_W-1:0]  nextWord;

  llrStageCtrl #(.PE(PE), .STW(STW)) ctrl_i (
    .opcode     (opcode),
    .startStage (startStage),
    .ctrl       (ctrl)
  );

  llrStageDatapath #(.PE(PE), .STW(STW)) dp_i (
    .ctrl       (ctrl),
    .startStage (startStage),
    .word       (inWord),
    .beta       (partialSum),
    .result     (nextWord)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outReject <= 1'b0;
      outWord   <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outReject <= ctrl.reject;
        outWord   <= nextWord;
      end
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  a_r10_bad_opcode: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode > 4'd8) |=> outReject);

  a_r10_reject_passthru: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && ctrl.reject) |=> (outWord == $past(inWord)));

endmodule

// File: tb/llrStageUnit_tb_top.sv
`timescale 1ns/1ps
module llrStageUnit_tb_top;

  localparam int PE  = 32;
  localparam int STW = 5;
  localparam int W   = 6;
  localparam int NE  = 2 * PE;
  localparam int TH  = 5;
  localparam int KF  = 0;
  localparam int KG  = 1;
  localparam int KG0 = 2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              inValid = 1'b0;
  logic [3:0]        opcode = '0;
  logic [STW-1:0]    startStage = '0;
  logic [NE*W-1:0]   inWord = '0;
  logic [PE-1:0]     partialSum = '0;
  logic              outValid;
  logic              outReject;
  logic [NE*W-1:0]   outWord;

  int checks = 0;
  int errors = 0;
  int a   [NE];
  int expW[NE];

  always #2 clk = ~clk;

  llrStageUnit #(.PE(PE), .STW(STW)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode),
    .startStage(startStage), .inWord(inWord), .partialSum(partialSum),
    .outValid(outValid), .outReject(outReject), .outWord(outWord)
  );

  function automatic int clampL(input int x);
    if (x > 31) return 31;
    if (x < -32) return -32;
    return x;
  endfunction

  function automatic int refOp(input int k, input int x, input int y, input logic bt);
    int mx, my, m;
    if (k == KF) begin
      mx = x < 0 ? -x : x;
      my = y < 0 ? -y : y;
      m  = mx < my ? mx : my;
      return clampL(((x < 0) != (y < 0)) ? -m : m);
    end
    if (k == KG && bt) return clampL(y - x);
    return clampL(y + x);
  endfunction

  task automatic check(input string tag, input logic cond, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fillRandom(input int extremes);
    for (int i = 0; i < NE; i++) begin
      a[i] = int'($urandom_range(63)) - 32;
      if (extremes != 0 && (i % 5) == 0) a[i] = (i % 2) ? 31 : -32;
    end
    partialSum = PE'($urandom);
  endtask

  // compute expectation from the requirement text, returns expected reject
  task automatic model(input int op, input int st, output logic rej);
    int k[3];
    int n;
    logic [2:0] keep;
    int work[NE];
    logic hi;
    logic bad;
    int size, half, offS, offD, v;
    bad = 1'b0; n = 1; keep = 3'b001; k[0] = KF; k[1] = KF; k[2] = KF;
    case (op)
      0: k[0] = KG - 1;
      1: k[0] = KG;
      2: k[0] = KG0;
      3: begin n = 2; keep = 3'b011; end
      4: begin n = 3; keep = 3'b111; end
      5: begin n = 2; keep = 3'b010; k[0] = KG0; k[1] = KG0; end
      6: begin n = 3; keep = 3'b100; k[0] = KG0; k[1] = KG0; k[2] = KG0; end
      7: begin n = 2; keep = 3'b011; k[0] = KG; k[1] = KF; end
      8: begin n = 2; keep = 3'b010; k[0] = KF; k[1] = KG0; end
      default: bad = 1'b1;
    endcase
    hi  = st > TH;
    rej = bad || (hi && n != 1) || (!hi && st < n + 2);
    for (int i = 0; i < NE; i++) begin expW[i] = a[i]; work[i] = a[i]; end
    if (!rej) begin
      if (hi) begin
        for (int i = 0; i < PE; i++) expW[i] = refOp(k[0], a[i], a[i+PE], partialSum[i]);
      end else begin
        for (int j = 0; j < n; j++) begin
          size = 1 << (st - j);
          half = size / 2;
          offS = NE - 2 * size;
          offD = NE - size;
          for (int i = 0; i < half; i++) begin
            v = refOp(k[j], work[offS+i], work[offS+i+half], partialSum[i]);
            work[offD+i] = v;
            if (keep[j]) expW[offD+i] = v;
          end
        end
      end
    end
  endtask

  task automatic runOp(input string tag, input int op, input int st);
    logic rej;
    int bad, act;
    model(op, st, rej);
    @(negedge clk);
    for (int i = 0; i < NE; i++) inWord[i*W +: W] = W'(a[i]);
    opcode     = 4'(op);
    startStage = STW'(st);
    inValid    = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({tag, " valid"}, outValid === 1'b1, int'(outValid), 1);
    check({tag, " reject"}, outReject === rej, int'(outReject), int'(rej));
    bad = -1;
    for (int i = 0; i < NE; i++) begin
      act = int'($signed(outWord[i*W +: W]));
      if (bad < 0 && act != expW[i]) bad = i;
    end
    if (bad >= 0)
      check({tag, " word"}, 1'b0, int'($signed(outWord[bad*W +: W])), expW[bad]);
    else
      check({tag, " word"}, 1'b1, 0, 0);
  endtask

  task automatic testReset();
    check("R11 reset valid", outValid === 1'b0, int'(outValid), 0);
    check("R11 reset reject", outReject === 1'b0, int'(outReject), 0);
    check("R11 reset word", outWord === '0, 1, 0);
  endtask

  task automatic testSingles();
    fillRandom(1);
    a[0] = -32; a[16] = -32;     // F of -32,-32 -> +31
    a[1] = -32; a[17] = 5;
    runOp("R1 F stage5", 0, 5);
    fillRandom(1);
    runOp("R2 G stage4", 1, 4);
    fillRandom(0);
    a[32] = 31; a[40] = 31; a[33] = -32; a[41] = -32;
    runOp("R3 G0 stage4 saturation", 2, 4);
    fillRandom(1);
    runOp("R3 G0 ignores partial sums", 2, 3);
  endtask

  task automatic testMerged();
    fillRandom(1); runOp("R5 F2 stage5", 3, 5);
    fillRandom(1); runOp("R5 F3 stage5", 4, 5);
    fillRandom(0); runOp("R5 F2 stage4", 3, 4);
    fillRandom(1); runOp("R6 G0x2 stage4", 5, 4);
    fillRandom(1); runOp("R6 G0x3 stage5", 6, 5);
    fillRandom(1); runOp("R7 GF stage4", 7, 4);
    fillRandom(0); runOp("R7 GF stage5", 7, 5);
    fillRandom(1); runOp("R8 FG0 stage5", 8, 5);
    fillRandom(0); runOp("R8 FG0 stage4", 8, 4);
  endtask

  task automatic testSpare();
    fillRandom(1);
    runOp("R4 F3 packed", 4, 5);
    for (int i = NE - 4; i < NE; i++)
      check("R4 spare entry", int'($signed(outWord[i*W +: W])) == a[i],
            int'($signed(outWord[i*W +: W])), a[i]);
  endtask

  task automatic testHi();
    fillRandom(1); runOp("R9 F full width", 0, 6);
    fillRandom(1); runOp("R9 G full width", 1, 7);
    fillRandom(0); runOp("R9 G0 full width", 2, 9);
  endtask

  task automatic testReject();
    fillRandom(0); runOp("R10 bad opcode", 12, 4);
    fillRandom(0); runOp("R10 F3 below stage2", 4, 4);
    fillRandom(0); runOp("R10 merged above threshold", 5, 6);
    fillRandom(0); runOp("R10 single at stage2", 0, 2);
    fillRandom(0); runOp("R10 single lowest valid", 0, 3);
  endtask

  task automatic testPulse();
    fillRandom(0);
    runOp("R11 pulse", 0, 5);
    @(negedge clk);
    check("R11 valid drops", outValid === 1'b0, int'(outValid), 0);
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testSingles();
    testMerged();
    testSpare();
    testHi();
    testReject();
    testPulse();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule